// File: doc/BRIEF.md
# Multidrop Serial Receiver with Automatic Flow Control

This block is the receive half of one asynchronous serial channel. It samples the incoming line against a shared 16x oversampling tick, assembles characters of 7, 8 or 9 data bits with optional parity and one or two stop bits, and hands each accepted character to an external receive FIFO through a single-cycle push strobe. Four status flags describe the most recently completed character: break, framing error, parity error and overrun.

When 9-bit multidrop operation is selected, the ninth bit tags a character as an address (1) or data (0). An address equal to the programmed station address opens the channel and is itself discarded. Data characters are stored only while the channel is open. A non-matching address closes the channel. The block also drives an active-low request-to-send output from the FIFO fill level so that the remote transmitter stops before the FIFO overflows.

The receiver listens only after the FIFO enable is set and the receive enable then rises. The FIFO fill level and the full indication come from the FIFO and are inputs to this block.

Top module: `uart_mdrx_rx`

## Requirements
- R1: The receiver runs only while `fifo_en` is 1 and `rx_en` has risen from 0 to 1 with `fifo_en` already 1. If `rx_en` is raised first, or `fifo_en` falls, nothing is received until `rx_en` is lowered and raised again with `fifo_en` at 1.
- R2: A falling edge starts a character only if the line is still low 8 ticks later. Data bits are taken at bit centres, LSB first. `cfg_wlen` selects 0=7 bits, 1=8 bits and 2=9 bits (3 acts as 8 bits). `push_data` carries the bits zero-extended to 9 bits, and a low pulse shorter than half a bit pushes nothing.
- R3: `cfg_parity` selects 0=none, 1=odd, 2=even, 3=bit forced 0, 4=bit forced 1. A wrong parity bit sets `st_parity`, and the character is still pushed.
- R4: `cfg_stop2`=1 selects two stop bits. A low sample in any stop bit sets `st_frame`, and the character is still pushed.
- R5: A character that is low throughout, including parity and every stop bit, sets `st_break` and `st_frame` and is not pushed. The receiver then waits for the line to go high before it looks for the next start bit.
- R6: If a character that would be stored completes while `fifo_full` is 1, it is dropped and `st_overrun` is set.
- R7: With `cfg_mdrop`=1 and 9-bit length, an address equal to `cfg_addr` is not pushed. Data characters after it are pushed with bit 8 of `push_data` at 0.
- R8: In multidrop operation, data characters that arrive before any match, or after a non-matching address, are discarded.
- R9: One clock after `fifo_level` >= `rts_trig`, `rts_n` is 1.
- R10: One clock after `fifo_level` + 4 < `rts_trig`, `rts_n` is 0. Between the two thresholds it holds its value, and after reset it is 0.
- R11: All four status flags are 0 after reset. They are rewritten at the end of every character, address characters included, so they describe only the last character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Receive FIFO enabled |
| rx_en | input | 1 | Receiver enable |
| ovs_tick | input | 1 | One-clock pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line |
| cfg_wlen | input | 2 | Word length code |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_mdrop | input | 1 | Multidrop address filtering |
| cfg_addr | input | 8 | Station address |
| fifo_level | input | 7 | Current FIFO fill |
| fifo_full | input | 1 | FIFO full |
| rts_trig | input | 7 | Fill level that stops the remote sender |
| push_valid | output | 1 | Push strobe to the FIFO |
| push_data | output | 9 | Character pushed |
| rts_n | output | 1 | Active-low request to send |
| st_break | output | 1 | Last character was a break |
| st_frame | output | 1 | Last character had a bad stop bit |
| st_parity | output | 1 | Last character had a bad parity bit |
| st_overrun | output | 1 | Last character was lost to a full FIFO |

## Verification
The bench targets several corner cases. A short low glitch must not start a character; a receiver that starts on the edge alone would push garbage. An all-zero break must not be pushed, and the receiver must wait for the idle line before re-arming; otherwise it would store a zero byte or re-trigger on the held-low line. Enables raised in the wrong order must leave the receiver deaf. In multidrop operation, data before a match and after a mismatching address must be discarded, and a matched address must not be stored. RTS is compared on every clock through a sweep that rises through the trigger and falls back through the hysteresis band, so a missing hold region shows up as chatter.

// File: rtl/uart_mdrx_pkg.sv
package uart_mdrx_pkg;

   localparam logic [2:0] PM_NONE = 3'd0;
   localparam logic [2:0] PM_ODD  = 3'd1;
   localparam logic [2:0] PM_EVEN = 3'd2;
   localparam logic [2:0] PM_ZERO = 3'd3;
   localparam logic [2:0] PM_ONE  = 3'd4;

   typedef struct packed {
      logic [8:0] data;
      logic       par_err;
      logic       frm_err;
      logic       brk;
   } rxchar_t;

   function automatic logic [3:0] wlen_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd7;
         2'd2:    return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/mdrx_sampler.sv
module mdrx_sampler
   import uart_mdrx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] wlen,
   input  logic [2:0] pmode,
   input  logic       stop2,
   output logic       done_o,
   output rxchar_t    char_o
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] FULL = CW'(OVS - 1);

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("mdrx_sampler: OVS must be a power of two, at least 4");
   end

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW} st_e;

   st_e           st;
   logic [CW-1:0] tcnt;
   logic [3:0]    bidx;
   logic [8:0]    shreg;
   logic          par_q, zero_q, stop_bad, stop_hi;
   logic [3:0]    nb;
   logic          last_data, last_stop, perr, brk_now;

   always_comb begin
      nb        = wlen_bits(wlen);
      last_data = (bidx == nb - 4'd1);
      last_stop = !stop2 || bidx[0];
      brk_now   = zero_q && !rxd && !stop_hi;
      case (pmode)
         PM_ODD:  perr = ~(^shreg ^ par_q);
         PM_EVEN: perr = ^shreg ^ par_q;
         PM_ZERO: perr = par_q;
         PM_ONE:  perr = ~par_q;
         default: perr = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         tcnt     <= '0;
         bidx     <= '0;
         shreg    <= '0;
         par_q    <= 1'b0;
         zero_q   <= 1'b0;
         stop_bad <= 1'b0;
         stop_hi  <= 1'b0;
         done_o   <= 1'b0;
         char_o   <= '0;
      end else begin
         done_o <= 1'b0;
         if (!run) begin
            st <= S_IDLE;
         end else if (st == S_BRKW) begin
            if (rxd) st <= S_IDLE;
         end else if (tick) begin
            case (st)
               S_IDLE: if (!rxd) begin
                  st   <= S_START;
                  tcnt <= '0;
               end
               S_START: if (tcnt == HALF) begin
                  tcnt     <= '0;
                  bidx     <= '0;
                  shreg    <= '0;
                  par_q    <= 1'b0;
                  zero_q   <= 1'b1;
                  stop_bad <= 1'b0;
                  stop_hi  <= 1'b0;
                  st       <= rxd ? S_IDLE : S_DATA;
               end else tcnt <= tcnt + 1'b1;
               S_DATA: if (tcnt == FULL) begin
                  tcnt        <= '0;
                  shreg[bidx] <= rxd;
                  if (rxd) zero_q <= 1'b0;
                  if (last_data) begin
                     bidx <= '0;
                     st   <= (pmode == PM_NONE) ? S_STOP : S_PAR;
                  end else bidx <= bidx + 4'd1;
               end else tcnt <= tcnt + 1'b1;
               S_PAR: if (tcnt == FULL) begin
                  tcnt  <= '0;
                  par_q <= rxd;
                  if (rxd) zero_q <= 1'b0;
                  st    <= S_STOP;
               end else tcnt <= tcnt + 1'b1;
               S_STOP: if (tcnt == FULL) begin
                  tcnt <= '0;
                  if (last_stop) begin
                     done_o         <= 1'b1;
                     char_o.data    <= shreg;
                     char_o.par_err <= perr;
                     char_o.frm_err <= stop_bad || !rxd;
                     char_o.brk     <= brk_now;
                     st             <= brk_now ? S_BRKW : S_IDLE;
                  end else begin
                     bidx <= bidx + 4'd1;
                     if (rxd) stop_hi <= 1'b1;
                     else     stop_bad <= 1'b1;
                  end
               end else tcnt <= tcnt + 1'b1;
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mdrx_filter.sv
module mdrx_filter
   import uart_mdrx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  rxchar_t    char_i,
   input  logic       md_on,
   input  logic [7:0] addr,
   input  logic       fifo_full,
   output logic       push_valid,
   output logic [8:0] push_data,
   output logic       st_break,
   output logic       st_frame,
   output logic       st_parity,
   output logic       st_overrun
);
   logic match_q, is_addr, want;

   always_comb begin
      is_addr = md_on && char_i.data[8] && !char_i.brk;
      want    = !char_i.brk && (!md_on || (!char_i.data[8] && match_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q    <= 1'b0;
         push_valid <= 1'b0;
         push_data  <= '0;
         st_break   <= 1'b0;
         st_frame   <= 1'b0;
         st_parity  <= 1'b0;
         st_overrun <= 1'b0;
      end else begin
         push_valid <= 1'b0;
         if (!md_on) match_q <= 1'b0;
         if (done) begin
            st_break   <= char_i.brk;
            st_frame   <= char_i.frm_err;
            st_parity  <= char_i.par_err;
            st_overrun <= want && fifo_full;
            push_valid <= want && !fifo_full;
            push_data  <= md_on ? {1'b0, char_i.data[7:0]} : char_i.data;
            if (is_addr) match_q <= (char_i.data[7:0] == addr);
         end
      end
   end
endmodule

// File: rtl/mdrx_rts.sv
module mdrx_rts #(
   parameter int LVL_W = 7,
   parameter int HYST  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] trig,
   output logic             rts_n
);
   localparam int EW = LVL_W + 1;

   if (HYST < 1 || HYST >= (1 << LVL_W)) begin : g_bad_hyst
      $error("mdrx_rts: HYST out of range for LVL_W");
   end

   logic [EW-1:0] lvl_e, trig_e;
   logic          at_trig, below_band;

   always_comb begin
      lvl_e      = {1'b0, level};
      trig_e     = {1'b0, trig};
      at_trig    = lvl_e >= trig_e;
      below_band = (lvl_e + EW'(HYST)) < trig_e;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rts_n <= 1'b0;
      else if (at_trig)    rts_n <= 1'b1;
      else if (below_band) rts_n <= 1'b0;
   end
endmodule

// File: rtl/uart_mdrx_rx.sv
module uart_mdrx_rx
   import uart_mdrx_pkg::*;
#(
   parameter int FIFO_DEPTH  = 64,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RTS_HYST    = 4,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             rx_en,
   input  logic             ovs_tick,
   input  logic             rxd,
   input  logic [1:0]       cfg_wlen,
   input  logic [2:0]       cfg_parity,
   input  logic             cfg_stop2,
   input  logic             cfg_mdrop,
   input  logic [7:0]       cfg_addr,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             fifo_full,
   input  logic [LVL_W-1:0] rts_trig,
   output logic             push_valid,
   output logic [8:0]       push_data,
   output logic             rts_n,
   output logic             st_break,
   output logic             st_frame,
   output logic             st_parity,
   output logic             st_overrun
);
   if (FIFO_DEPTH < 8) begin : g_bad_depth
      $error("uart_mdrx_rx: FIFO_DEPTH must be at least 8");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("uart_mdrx_rx: SYNC_STAGES must be 0..4");
   end

   logic    rxd_s, rx_en_q, run_q, md_on, done;
   rxchar_t rx_char;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rxd_s = rxd;
   end else if (SYNC_STAGES == 1) begin : g_sync1
      logic s1;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) s1 <= 1'b1;
         else        s1 <= rxd;
      assign rxd_s = s1;
   end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sr <= '1;
         else        sr <= {sr[SYNC_STAGES-2:0], rxd};
      assign rxd_s = sr[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en_q <= 1'b0;
         run_q   <= 1'b0;
      end else begin
         rx_en_q <= rx_en;
         run_q   <= fifo_en && rx_en && (run_q || !rx_en_q);
      end
   end

   assign md_on = cfg_mdrop && (cfg_wlen == 2'd2);

   mdrx_sampler #(.OVS(OVS)) u_smp (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick(ovs_tick), .rxd(rxd_s),
      .wlen(cfg_wlen), .pmode(cfg_parity), .stop2(cfg_stop2),
      .done_o(done), .char_o(rx_char)
   );

   mdrx_filter u_flt (
      .clk(clk), .rst_n(rst_n), .done(done), .char_i(rx_char), .md_on(md_on),
      .addr(cfg_addr), .fifo_full(fifo_full),
      .push_valid(push_valid), .push_data(push_data),
      .st_break(st_break), .st_frame(st_frame), .st_parity(st_parity),
      .st_overrun(st_overrun)
   );

   mdrx_rts #(.LVL_W(LVL_W), .HYST(RTS_HYST)) u_rts (
      .clk(clk), .rst_n(rst_n), .level(fifo_level), .trig(rts_trig), .rts_n(rts_n)
   );
endmodule

// File: rtl/mdrx_checks.sv
module mdrx_checks #(
   parameter int LVL_W = 7,
   parameter int HYST  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             md_on,
   input logic             fifo_full,
   input logic [LVL_W-1:0] fifo_level,
   input logic [LVL_W-1:0] rts_trig,
   input logic             rts_n,
   input logic             push_valid,
   input logic [8:0]       push_data
);
   localparam int EW = LVL_W + 1;
   logic [EW-1:0] lv, tg;
   logic          hi_zone, lo_zone;
   assign lv      = {1'b0, fifo_level};
   assign tg      = {1'b0, rts_trig};
   assign hi_zone = lv >= tg;
   assign lo_zone = (lv + EW'(HYST)) < tg;

   AST_RTS_OFF_AT_TRIG: assert property (@(posedge clk) disable iff (!rst_n) hi_zone |=> rts_n); // R9
   AST_RTS_ON_BELOW: assert property (@(posedge clk) disable iff (!rst_n) lo_zone |=> !rts_n); // R10
   AST_RTS_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n) (!hi_zone && !lo_zone) |=> $stable(rts_n)); // R10
   AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) push_valid |-> !$past(fifo_full)); // R6
   AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (!$past(run) && !$past(run, 2)) |-> !push_valid); // R1
   AST_MD_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (push_valid && $past(md_on)) |-> !push_data[8]); // R7
endmodule

bind uart_mdrx_rx mdrx_checks #(.LVL_W(LVL_W), .HYST(RTS_HYST)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .md_on(md_on), .fifo_full(fifo_full),
   .fifo_level(fifo_level), .rts_trig(rts_trig), .rts_n(rts_n),
   .push_valid(push_valid), .push_data(push_data)
);

// File: tb/sim_uart_mdrx_rx.sv
module sim_uart_mdrx_rx;
   localparam int CLK_NS   = 10;
   localparam int TICK_DIV = 4;
   localparam int BIT_CLKS = 16 * TICK_DIV;
   localparam int LW       = 7;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          fifo_en = 0, rx_en = 0, ovs_tick = 0, rxd = 1;
   logic [1:0]    cfg_wlen = 2'd1;
   logic [2:0]    cfg_parity = 3'd0;
   logic          cfg_stop2 = 0, cfg_mdrop = 0;
   logic [7:0]    cfg_addr = 8'h00;
   logic [LW-1:0] fifo_level = '0, rts_trig = 7'd10;
   logic          fifo_full = 0;
   logic          push_valid, rts_n, st_break, st_frame, st_parity, st_overrun;
   logic [8:0]    push_data;

   uart_mdrx_rx u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_en(rx_en), .ovs_tick(ovs_tick),
      .rxd(rxd), .cfg_wlen(cfg_wlen), .cfg_parity(cfg_parity), .cfg_stop2(cfg_stop2),
      .cfg_mdrop(cfg_mdrop), .cfg_addr(cfg_addr), .fifo_level(fifo_level),
      .fifo_full(fifo_full), .rts_trig(rts_trig), .push_valid(push_valid),
      .push_data(push_data), .rts_n(rts_n), .st_break(st_break), .st_frame(st_frame),
      .st_parity(st_parity), .st_overrun(st_overrun)
   );

   always #(CLK_NS / 2) clk = ~clk;

   int total = 0, bad = 0, n_push = 0, tdiv = 0;
   logic [8:0] exp_q[$];
   bit exp_rts = 0, match = 0, done_flag = 0;
   bit e_brk = 0, e_frm = 0, e_par = 0, e_ovr = 0;
   int wl = 8, pm = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      ovs_tick <= (tdiv == TICK_DIV - 1);
      tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
   end

   // behavioural flow-control model, evaluated at each edge
   always @(posedge clk) begin
      if (!rst_n) exp_rts = 0;
      else if (int'(fifo_level) >= int'(rts_trig)) exp_rts = 1;
      else if (int'(fifo_level) + 4 < int'(rts_trig)) exp_rts = 0;
   end

   always @(negedge clk) begin
      logic [8:0] e;
      if (rst_n && !done_flag) begin
         chk(rts_n == exp_rts, "R9/R10", "rts_n", rts_n, exp_rts);
         if (push_valid) begin
            n_push++;
            if (exp_q.size() == 0) chk(0, "R2", "unexpected push", push_data, -1);
            else begin
               e = exp_q.pop_front();
               chk(push_data == e, "R2", "push_data", push_data, e);
            end
         end
      end
   end

   task automatic set_cfg(input int bits, input int pmode, input bit s2, input bit mdp);
      wl = bits; pm = pmode;
      cfg_wlen   = (bits == 7) ? 2'd0 : (bits == 9) ? 2'd2 : 2'd1;
      cfg_parity = 3'(pmode);
      cfg_stop2  = s2;
      cfg_mdrop  = mdp;
      match      = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic drive_bit(input logic b);
      rxd = b;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send(input logic [8:0] d, input bit bad_par, input bit bad_stop, input bit live);
      logic [8:0] m;
      logic pb;
      bit md, want;
      m  = d & ((9'h1 << wl) - 9'h1);
      md = cfg_mdrop && (wl == 9);
      case (pm)
         1: pb = ~(^m);
         2: pb = ^m;
         3: pb = 1'b0;
         default: pb = 1'b1;
      endcase
      if (bad_par) pb = ~pb;
      if (live) begin
         want  = md ? (!m[8] && match) : 1;
         if (md && m[8]) match = (m[7:0] == cfg_addr);
         e_brk = 0; e_frm = bad_stop; e_par = bad_par && (pm != 0);
         e_ovr = want && fifo_full;
         if (want && !fifo_full) exp_q.push_back(md ? {1'b0, m[7:0]} : m);
      end
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < wl; i++) drive_bit(m[i]);
      if (pm != 0) drive_bit(pb);
      drive_bit(!bad_stop);
      if (cfg_stop2) drive_bit(1'b1);
      rxd = 1'b1;
      repeat (16) @(negedge clk);
   endtask

   task automatic check_flags(input string req);
      chk(st_break == e_brk, req, "st_break", st_break, e_brk);
      chk(st_frame == e_frm, req, "st_frame", st_frame, e_frm);
      chk(st_parity == e_par, req, "st_parity", st_parity, e_par);
      chk(st_overrun == e_ovr, req, "st_overrun", st_overrun, e_ovr);
   endtask

   task automatic summary;
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      int p0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 R11: reset state
      chk(rts_n == 0, "R10", "reset rts_n", rts_n, 0);
      chk(push_valid == 0, "R11", "reset push", push_valid, 0);
      check_flags("R11");

      // R1: wrong enable order keeps the receiver deaf
      rx_en = 1; repeat (4) @(negedge clk);
      fifo_en = 1; repeat (4) @(negedge clk);
      p0 = n_push;
      send(9'h055, 0, 0, 0);
      chk(n_push == p0, "R1", "push count after wrong order", n_push, p0);
      rx_en = 0; repeat (4) @(negedge clk);
      rx_en = 1; repeat (4) @(negedge clk);

      // R2: 8 data bits, no parity
      set_cfg(8, 0, 0, 0);
      send(9'h0A5, 0, 0, 1); check_flags("R2");
      send(9'h03C, 0, 0, 1); check_flags("R2");
      // R3: 7 bits even parity, good then bad
      set_cfg(7, 2, 0, 0);
      send(9'h05A, 0, 0, 1); check_flags("R3");
      send(9'h033, 1, 0, 1); check_flags("R3");
      set_cfg(8, 1, 0, 0);
      send(9'h081, 0, 0, 1); check_flags("R3");
      set_cfg(8, 3, 0, 0);
      send(9'h0F0, 1, 0, 1); check_flags("R3");
      set_cfg(8, 4, 0, 0);
      send(9'h00F, 0, 0, 1); check_flags("R3");
      // R4: 9 bits odd parity, two stop bits
      set_cfg(9, 1, 1, 0);
      send(9'h1C3, 0, 0, 1); check_flags("R4");
      send(9'h0AA, 0, 1, 1); check_flags("R4");

      // R2: glitch shorter than half a bit
      set_cfg(8, 0, 0, 0);
      p0 = n_push;
      rxd = 0; repeat (3 * TICK_DIV) @(negedge clk);
      rxd = 1; repeat (2 * BIT_CLKS) @(negedge clk);
      chk(n_push == p0, "R2", "push after glitch", n_push, p0);

      // R5: break, then recovery
      p0 = n_push;
      rxd = 0; repeat (11 * BIT_CLKS) @(negedge clk);
      rxd = 1; repeat (BIT_CLKS) @(negedge clk);
      e_brk = 1; e_frm = 1; e_par = 0; e_ovr = 0;
      check_flags("R5");
      chk(n_push == p0, "R5", "push after break", n_push, p0);
      send(9'h066, 0, 0, 1); check_flags("R11");

      // R6: overrun
      fifo_full = 1;
      send(9'h012, 0, 0, 1); check_flags("R6");
      fifo_full = 0;
      send(9'h034, 0, 0, 1); check_flags("R6");

      // R7 R8: multidrop filtering
      cfg_addr = 8'h42;
      set_cfg(9, 0, 0, 1);
      send(9'h011, 0, 0, 1); check_flags("R8");
      send(9'h142, 0, 0, 1); check_flags("R7");
      send(9'h077, 0, 0, 1); check_flags("R7");
      send(9'h150, 0, 0, 1); check_flags("R8");
      send(9'h022, 0, 0, 1); check_flags("R8");
      send(9'h142, 0, 0, 1);
      send(9'h0FF, 0, 0, 1); check_flags("R7");
      chk(exp_q.size() == 0, "R7", "pending pushes", exp_q.size(), 0);

      // R1: FIFO disable stops reception
      set_cfg(8, 0, 0, 0);
      fifo_en = 0; repeat (4) @(negedge clk);
      p0 = n_push;
      send(9'h099, 0, 0, 0);
      chk(n_push == p0, "R1", "push while disabled", n_push, p0);

      // R9 R10: level sweep through trigger and hysteresis band
      rts_trig = 7'd10;
      for (int l = 0; l <= 12; l++) begin
         fifo_level = 7'(l); repeat (3) @(negedge clk);
      end
      chk(rts_n == 1, "R9", "rts_n above trigger", rts_n, 1);
      for (int l = 12; l >= 0; l--) begin
         fifo_level = 7'(l); repeat (3) @(negedge clk);
         if (l == 7) chk(rts_n == 1, "R10", "rts_n in band", rts_n, 1);
      end
      chk(rts_n == 0, "R10", "rts_n after drain", rts_n, 0);
      rts_trig = 7'd2; repeat (4) @(negedge clk);
      chk(rts_n == 0, "R10", "rts_n hold small trig", rts_n, 0);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2", "pending pushes at end", exp_q.size(), 0);
      summary();
   end
endmodule